// File: doc/BRIEF.md
# Two-Operand Hexadecimal Entry Display

This block lets a user enter two 16-bit operands through a single bank of sixteen switches and see both at once on eight seven-segment digits. The first operand is set on the switches and latched into an internal register by a pushbutton-driven clock edge. The switches are then free to be set to the second operand. The stored operand appears in hexadecimal on the upper group of four digits. The lower group of four digits shows the present switch value at all times.

Every digit has its own seven segment lines, so no display multiplexing is involved. Segments are active-low. An active-low asynchronous reset empties the stored operand, and the upper digits then read "0000" until the next capture.

Top module: `hexdisp_top`

## Requirements
- R1: While `rst_n` is low, the stored operand is zero, and `seg_d7`..`seg_d4` each show the glyph for 0 (7'b1000000).
- R2: On a rising edge of `cap_clk` with `rst_n` high, the stored operand takes the value of `sw_val` present at that edge.
- R3: Between rising edges of `cap_clk`, the stored operand does not change, whatever `sw_val` does. A falling edge of `cap_clk` does not load it.
- R4: The stored operand is shown on the upper digits. `seg_d7` shows bits 15:12, `seg_d6` shows 11:8, `seg_d5` shows 7:4 and `seg_d4` shows 3:0.
- R5: The lower digits follow `sw_val` combinationally, with no clock edge needed. `seg_d3` shows bits 15:12, `seg_d2` shows 11:8, `seg_d1` shows 7:4 and `seg_d0` shows 3:0.
- R6: Each digit decodes a nibble to an active-low pattern, where bit 0 is segment a and bit 6 is segment g. The patterns, written active-high as {g..a}, are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71. The output is the bitwise inverse of each value.
- R7: A fall of `rst_n` between `cap_clk` edges clears the stored operand at once, with no clock edge.
- R8: While `rst_n` is held low, rising edges of `cap_clk` do not load the stored operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cap_clk | input | 1 | Capture clock from a pushbutton; its rising edge loads the stored operand |
| rst_n | input | 1 | Asynchronous reset, active-low |
| sw_val | input | 16 | Switch bank value |
| seg_d0 | output | 7 | Digit 0 (B bits 3:0), active-low segments a..g on bits 0..6 |
| seg_d1 | output | 7 | Digit 1 (B bits 7:4) |
| seg_d2 | output | 7 | Digit 2 (B bits 11:8) |
| seg_d3 | output | 7 | Digit 3 (B bits 15:12) |
| seg_d4 | output | 7 | Digit 4 (A bits 3:0) |
| seg_d5 | output | 7 | Digit 5 (A bits 7:4) |
| seg_d6 | output | 7 | Digit 6 (A bits 11:8) |
| seg_d7 | output | 7 | Digit 7 (A bits 15:12) |

## Verification
The bench drives values with four different nibbles, such as 16'h1234 and 16'hC0DE. Because every nibble differs, a swapped digit order in either group shows up as a wrong glyph. It then changes the switches without a clock edge, and with only a falling edge, which separates a held register from a live path. Repeated-nibble words 16'h0000 through 16'hFFFF are captured and shown together, so all sixteen glyphs are compared on all eight digit positions. A reset applied midway between edges, and capture edges applied during reset, separate asynchronous clearing from loading.

// File: rtl/hexdisp_pkg.sv
package hexdisp_pkg;
  localparam int NIB_W = 4;
  localparam int SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;
  // active-low glyph for zero, used for reset display
  localparam seg_t SEG_ZERO = 7'b1000000;
endpackage

// File: rtl/hexdisp_opnd_reg.sv
module hexdisp_opnd_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/hexdisp_seg_dec.sv
module hexdisp_seg_dec
  import hexdisp_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  output seg_t             seg_n
);
  seg_t lit; // active-high, bit 0 = a

  always_comb begin
    unique case (nib)
      4'h0: lit = 7'b0111111;
      4'h1: lit = 7'b0000110;
      4'h2: lit = 7'b1011011;
      4'h3: lit = 7'b1001111;
      4'h4: lit = 7'b1100110;
      4'h5: lit = 7'b1101101;
      4'h6: lit = 7'b1111101;
      4'h7: lit = 7'b0000111;
      4'h8: lit = 7'b1111111;
      4'h9: lit = 7'b1101111;
      4'hA: lit = 7'b1110111;
      4'hB: lit = 7'b1111100;
      4'hC: lit = 7'b0111001;
      4'hD: lit = 7'b1011110;
      4'hE: lit = 7'b1111001;
      default: lit = 7'b1110001;
    endcase
    seg_n = ~lit;
  end
endmodule

// File: rtl/hexdisp_digit_bank.sv
module hexdisp_digit_bank
  import hexdisp_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int WORD_W = DIGITS * NIB_W
) (
  input  logic [WORD_W-1:0]            word,
  output logic [DIGITS-1:0][SEG_W-1:0] segs
);
  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    hexdisp_seg_dec u_dec (
      .nib   (word[i*NIB_W +: NIB_W]),
      .seg_n (segs[i])
    );
  end
endmodule

// File: rtl/hexdisp_top.sv
module hexdisp_top
  import hexdisp_pkg::*;
#(
  parameter int DIGITS_PER_GROUP = 4,
  localparam int WORD_W = DIGITS_PER_GROUP * NIB_W
) (
  input  logic              cap_clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] sw_val,
  output logic [SEG_W-1:0]  seg_d0,
  output logic [SEG_W-1:0]  seg_d1,
  output logic [SEG_W-1:0]  seg_d2,
  output logic [SEG_W-1:0]  seg_d3,
  output logic [SEG_W-1:0]  seg_d4,
  output logic [SEG_W-1:0]  seg_d5,
  output logic [SEG_W-1:0]  seg_d6,
  output logic [SEG_W-1:0]  seg_d7
);
  logic [WORD_W-1:0] opa_q;
  logic [DIGITS_PER_GROUP-1:0][SEG_W-1:0] segs_lo, segs_hi;

  hexdisp_opnd_reg #(.WIDTH(WORD_W)) u_opa (
    .clk   (cap_clk),
    .rst_n (rst_n),
    .d     (sw_val),
    .q     (opa_q)
  );

  hexdisp_digit_bank #(.DIGITS(DIGITS_PER_GROUP)) u_bank_hi (
    .word (opa_q),
    .segs (segs_hi)
  );

  hexdisp_digit_bank #(.DIGITS(DIGITS_PER_GROUP)) u_bank_lo (
    .word (sw_val),
    .segs (segs_lo)
  );

  assign seg_d0 = segs_lo[0];
  assign seg_d1 = segs_lo[1];
  assign seg_d2 = segs_lo[2];
  assign seg_d3 = segs_lo[3];
  assign seg_d4 = segs_hi[0];
  assign seg_d5 = segs_hi[1];
  assign seg_d6 = segs_hi[2];
  assign seg_d7 = segs_hi[3];
endmodule

// File: rtl/hexdisp_checker.sv
module hexdisp_checker
  import hexdisp_pkg::*;
(
  input logic              cap_clk,
  input logic              rst_n,
  input logic [15:0]       sw_val,
  input logic [15:0]       opa_q,
  input logic [SEG_W-1:0]  seg_d0,
  input logic [SEG_W-1:0]  seg_d4,
  input logic [SEG_W-1:0]  seg_d5,
  input logic [SEG_W-1:0]  seg_d6,
  input logic [SEG_W-1:0]  seg_d7
);
  // R2: value present at one edge is held and seen at the next edge
  a_r2_capture: assert property (@(posedge cap_clk) disable iff (!rst_n)
    1'b1 |=> (opa_q == $past(sw_val)));

  // R1: reset shows zero on the upper group (checks the reset itself)
  a_r1_reset_zero: assert property (@(posedge cap_clk)
    (!rst_n) |-> (seg_d7 == SEG_ZERO && seg_d4 == SEG_ZERO));

  // R4: a zero operand shows zero glyphs on every upper digit
  a_r4_zero_operand: assert property (@(posedge cap_clk) disable iff (!rst_n)
    (opa_q == 16'h0) |-> (seg_d4 == SEG_ZERO && seg_d5 == SEG_ZERO &&
                           seg_d6 == SEG_ZERO && seg_d7 == SEG_ZERO));

  // R5: zero switches show zero on the low digit
  a_r5_live_zero: assert property (@(posedge cap_clk) disable iff (!rst_n)
    (sw_val == 16'h0) |-> (seg_d0 == SEG_ZERO));

  // R6: every glyph lights at least two segments
  a_r6_glyph_lit: assert property (@(posedge cap_clk) disable iff (!rst_n)
    ($countones(~seg_d0) >= 2) && ($countones(~seg_d7) >= 2));
endmodule

bind hexdisp_top hexdisp_checker u_chk (
  .cap_clk (cap_clk),
  .rst_n   (rst_n),
  .sw_val  (sw_val),
  .opa_q   (opa_q),
  .seg_d0  (seg_d0),
  .seg_d4  (seg_d4),
  .seg_d5  (seg_d5),
  .seg_d6  (seg_d6),
  .seg_d7  (seg_d7)
);

// File: tb/tb_hexdisp_top.sv
module tb_hexdisp_top;
  logic clk = 1'b0;
  logic cap_clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] sw_val = 16'h0;
  logic [6:0] seg_d0, seg_d1, seg_d2, seg_d3, seg_d4, seg_d5, seg_d6, seg_d7;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  hexdisp_top dut (
    .cap_clk (cap_clk), .rst_n (rst_n), .sw_val (sw_val),
    .seg_d0 (seg_d0), .seg_d1 (seg_d1), .seg_d2 (seg_d2), .seg_d3 (seg_d3),
    .seg_d4 (seg_d4), .seg_d5 (seg_d5), .seg_d6 (seg_d6), .seg_d7 (seg_d7)
  );

  // independent glyph model: active-high {g..a}, then inverted
  function automatic logic [6:0] glyph(input logic [3:0] v);
    logic [6:0] hi;
    case (v)
      0: hi = 7'h3F;  1: hi = 7'h06;  2: hi = 7'h5B;  3: hi = 7'h4F;
      4: hi = 7'h66;  5: hi = 7'h6D;  6: hi = 7'h7D;  7: hi = 7'h07;
      8: hi = 7'h7F;  9: hi = 7'h6F;  10: hi = 7'h77; 11: hi = 7'h7C;
      12: hi = 7'h39; 13: hi = 7'h5E; 14: hi = 7'h79; default: hi = 7'h71;
    endcase
    return ~hi;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [6:0] act, input logic [6:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_hi(input string req, input logic [15:0] a);
    chk(req, "seg_d7", seg_d7, glyph(a[15:12]));
    chk(req, "seg_d6", seg_d6, glyph(a[11:8]));
    chk(req, "seg_d5", seg_d5, glyph(a[7:4]));
    chk(req, "seg_d4", seg_d4, glyph(a[3:0]));
  endtask

  task automatic chk_lo(input string req, input logic [15:0] b);
    chk(req, "seg_d3", seg_d3, glyph(b[15:12]));
    chk(req, "seg_d2", seg_d2, glyph(b[11:8]));
    chk(req, "seg_d1", seg_d1, glyph(b[7:4]));
    chk(req, "seg_d0", seg_d0, glyph(b[3:0]));
  endtask

  task automatic press();
    @(negedge clk); cap_clk = 1'b1;
    @(negedge clk); cap_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sw_val = 16'hBEEF;
    @(negedge clk);
    chk_hi("R1", 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk_hi("R1", 16'h0000);
  endtask

  task automatic t_capture_hold();
    sw_val = 16'h1234; press();
    chk_hi("R2 R4", 16'h1234);
    sw_val = 16'hC0DE; @(negedge clk);
    chk_lo("R5", 16'hC0DE);
    chk_hi("R3", 16'h1234);
    cap_clk = 1'b1; @(negedge clk);   // rise loads C0DE
    sw_val = 16'h5A69; cap_clk = 1'b0; // fall must not load
    @(negedge clk);
    chk_hi("R3", 16'hC0DE);
    chk_lo("R5", 16'h5A69);
  endtask

  task automatic t_async_reset();
    sw_val = 16'h9F37; press();
    chk_hi("R2", 16'h9F37);
    @(posedge clk); #2 rst_n = 1'b0; #1;
    chk_hi("R7", 16'h0000);
    cap_clk = 1'b1; #3 cap_clk = 1'b0;
    @(negedge clk);
    chk_hi("R8", 16'h0000);
    chk_lo("R5", 16'h9F37);
    rst_n = 1'b1; @(negedge clk);
    chk_hi("R8", 16'h0000);
  endtask

  task automatic t_glyphs();
    for (int v = 0; v < 16; v++) begin
      sw_val = {4{v[3:0]}};
      press();
      chk_hi("R6", {4{v[3:0]}});
      chk_lo("R6", {4{v[3:0]}});
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_capture_hold();
    t_async_reset();
    t_glyphs();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule